// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a small register bus with one-cycle read and write strobes. Software sets a reload value and then starts the counter with a control write. From then on the counter counts down by one on every clock. When it reaches zero it raises a pending event and then starts over. In reload mode it restarts from the programmed value, which gives periodic or one-shot ticks. In free-running mode it restarts from all ones, so the bitwise inverse of the current value works as a monotonic clock source.

The pending event drives one level interrupt line, which the control word can mask. Software acknowledges the event by reading a dedicated acknowledge address; no write is needed. The core is a two-state machine. ST_OFF holds the counter still. ST_RUN decrements it. Two transitions leave a state: T_START (a control write with the enable bit set while in ST_OFF) loads the counter and enters ST_RUN, and T_STOP (a control write with the enable bit clear while in ST_RUN) returns to ST_OFF. Every other cycle stays in the same state: T_HOLD in ST_OFF, T_COUNT in ST_RUN.

Top module: `tick_timer`

## Requirements
- R1: After reset every readable location returns 0, the state is ST_OFF and `irq` is low.
- R2: Offset 0x00 holds the reload value. A write stores all 32 bits and a read returns the last value written.
- R3: Offset 0x08 is the control word. Bit 0 enables, bit 1 selects reload mode (1) or free-running mode (0), and bit 2 masks the interrupt (1 = masked). A read returns only these three bits; bits 31..3 read as 0.
- R4: T_START copies the reload value into the counter on the control-write edge. In ST_RUN the counter falls by one per clock, and offset 0x04 reads the current value.
- R5: In reload mode, the clock edge after the counter holds zero sets the pending event and reloads the counter. With reload value L, the first event appears L+1 clock edges after the starting write, and events then repeat every L+1 cycles.
- R6: In free-running mode, the edge after zero sets the pending event and the counter becomes 0xFFFFFFFF. The inverse of the value then increases.
- R7: Control value 6 (or any value with bit 0 clear) takes T_STOP. The counter then holds its value and raises no further events.
- R8: Offset 0x10 bit 0 reads the pending event ANDed with NOT mask, and `irq` equals that bit. A masked event stays latched and shows on `irq` once the mask is cleared.
- R9: A read of offset 0x0C clears the pending event and returns 0. If a new event occurs on the same edge, the event wins and stays pending.
- R10: A write to offsets 0x04, 0x0C or 0x10 has no effect: the counter and the pending event are unchanged.
- R11: A control write with bit 0 set while in ST_RUN does not reload the counter. A write of a new reload value while running does not change the count, and takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe (side effects only at offset 0x0C) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt, pending event and not masked |

## Verification
A wrong count shows at offset 0x04 in the cycle after the faulty edge. It also shows on `irq` as an event that comes early or late, because the first event must come exactly L+1 edges after the starting write. A lost or stuck pending flag shows on `irq` and at offset 0x10 in the cycle after the acknowledge read or the zero cycle. A flag hidden by the mask becomes visible in the cycle after the mask is cleared. A state machine stuck in the wrong state shows as a value at 0x04 that changes while stopped, or one that holds while running, from one read to the next.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_VALUE  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h10;

    typedef enum logic {ST_OFF = 1'b0, ST_RUN = 1'b1} tmr_state_e;

    typedef struct packed {
        logic mask;
        logic reload;
        logic en;
    } tmr_ctrl_t;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      count,
    input  logic              stat_vis,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      reload_val,
    output logic              mode_reload,
    output logic              irq_mask,
    output logic              ctl_wr,
    output logic              ctl_en_new,
    output logic              ack_rd
);
    localparam int CW = $bits(tmr_ctrl_t);

    tmr_ctrl_t    ctrl_q;
    logic [W-1:0] reload_q;

    assign ctl_wr      = wr && (addr == OFS_CTRL);
    assign ctl_en_new  = wdata[0];
    assign ack_rd      = rd && (addr == OFS_ACK);
    assign reload_val  = reload_q;
    assign mode_reload = ctrl_q.reload;
    assign irq_mask    = ctrl_q.mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else if (wr) begin
            if (addr == OFS_RELOAD) reload_q <= wdata;
            if (addr == OFS_CTRL)   ctrl_q   <= tmr_ctrl_t'(wdata[CW-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_RELOAD: rdata = reload_q;
            OFS_VALUE:  rdata = count;
            OFS_CTRL:   rdata = {{(W-CW){1'b0}}, ctrl_q};
            OFS_STAT:   rdata = {{(W-1){1'b0}}, stat_vis};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tick_timer_fsm.sv
module tick_timer_fsm
    import tick_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr,
    input  logic         ctl_en_new,
    input  logic         mode_reload,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         running,
    output logic         zero_evt
);
    tmr_state_e   state_q, state_d;
    logic [W-1:0] count_q, count_d;
    logic         go, halt;

    assign go   = ctl_wr && ctl_en_new;
    assign halt = ctl_wr && !ctl_en_new;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        count_d  = count_q;
        zero_evt = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (go) begin                 // T_START
                    state_d = ST_RUN;
                    count_d = reload_val;
                end                           // else T_HOLD
            end
            ST_RUN: begin
                if (halt) begin               // T_STOP
                    state_d = ST_OFF;
                end else if (count_q == '0) begin  // T_COUNT at zero
                    zero_evt = 1'b1;
                    count_d  = mode_reload ? reload_val : '1;
                end else begin                // T_COUNT
                    count_d = count_q - 1'b1;
                end
            end
        endcase
    end

    assign count   = count_q;
    assign running = (state_q == ST_RUN);
endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_evt,
    input  logic ack_rd,
    input  logic irq_mask,
    output logic stat_vis
);
    logic raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        raw_q <= 1'b0;
        else if (zero_evt) raw_q <= 1'b1;   // a new event beats the acknowledge
        else if (ack_rd)   raw_q <= 1'b0;
    end

    assign stat_vis = raw_q && !irq_mask;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq
);
    logic [W-1:0] count, reload_val;
    logic         mode_reload, irq_mask, ctl_wr, ctl_en_new, ack_rd;
    logic         running, zero_evt, stat_vis;

    tick_timer_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .count(count), .stat_vis(stat_vis), .rdata(bus_rdata),
        .reload_val(reload_val), .mode_reload(mode_reload), .irq_mask(irq_mask),
        .ctl_wr(ctl_wr), .ctl_en_new(ctl_en_new), .ack_rd(ack_rd)
    );

    tick_timer_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en_new(ctl_en_new),
        .mode_reload(mode_reload), .reload_val(reload_val), .count(count),
        .running(running), .zero_evt(zero_evt)
    );

    tick_timer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .ack_rd(ack_rd),
        .irq_mask(irq_mask), .stat_vis(stat_vis)
    );

    assign irq = stat_vis;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         running,
    input logic [W-1:0] count,
    input logic [W-1:0] reload_val,
    input logic         mode_reload,
    input logic         irq_mask,
    input logic         ctl_wr,
    input logic         ctl_en_new,
    input logic         zero_evt,
    input logic         ack_rd,
    input logic         raw,
    input logic         irq
);
    p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running && ctl_wr && ctl_en_new |=> running && count == $past(reload_val));

    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running && count != '0 && !ctl_wr |=> count == $past(count) - 1'b1);

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running && count == '0 && mode_reload && !ctl_wr |=> count == $past(reload_val));

    p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> raw);

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running && count == '0 && !mode_reload && !ctl_wr |=> count == '1);

    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !(ctl_wr && ctl_en_new) |=> $stable(count));

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd && !zero_evt |=> !raw);
endmodule

bind tick_timer tick_timer_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(u_fsm.running), .count(count),
    .reload_val(reload_val), .mode_reload(mode_reload), .irq_mask(irq_mask),
    .ctl_wr(ctl_wr), .ctl_en_new(ctl_en_new), .zero_evt(zero_evt),
    .ack_rd(ack_rd), .raw(u_irq.raw_q), .irq(irq)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] rv, rv2;

    always #2 clk = ~clk;

    tick_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic stop_and_ack();
        logic [31:0] t;
        wr(5'h08, 32'h6);
        rd(5'h0C, t);
    endtask

    task automatic t_reset_r1();
        for (int a = 0; a <= 16; a += 4) begin
            rd(5'(a), rv);
            check("R1 reset read", rv, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regs_r2_r3();
        wr(5'h00, 32'hA5C3_0F1E);
        rd(5'h00, rv);
        check("R2 reload readback", rv, 32'hA5C3_0F1E);
        wr(5'h08, 32'hFFFF_FFFE);
        rd(5'h08, rv);
        check("R3 control readback", rv, 32'h6);
        rd(5'h04, rv);
        check("R3 bit0 clear leaves counter off", rv, 32'h0);
    endtask

    task automatic t_count_r4();
        wr(5'h00, 32'h100);
        wr(5'h08, 32'h3);
        rd(5'h04, rv);
        check("R4 loaded on start", rv, 32'h100);
        rd(5'h04, rv);
        check("R4 decrement", rv, 32'hFF);
        stop_and_ack();
    endtask

    task automatic t_period_r5_r9();
        int n;
        wr(5'h00, 32'hF);
        wr(5'h08, 32'h3);
        for (int k = 1; k <= 16; k++) begin
            if (k < 16) begin
                if (irq) begin check("R5 early event", 32'(k), 32'd16); break; end
            end
            @(negedge clk);
        end
        check("R5 first event after L+1 edges", {31'b0, irq}, 32'h1);
        rd(5'h0C, rv);                       // ack edge E17
        check("R9 ack read data", rv, 32'h0);
        check("R9 ack clears", {31'b0, irq}, 32'h0);
        n = 0;
        while (!irq && n < 100) begin @(negedge clk); n++; end
        check("R5 period L+1", 32'(n + 1), 32'd16);
        repeat (15) @(negedge clk);          // next edge is an event edge
        rd(5'h0C, rv);
        check("R9 event wins over same-edge ack", {31'b0, irq}, 32'h1);
        rd(5'h0C, rv);
        check("R9 second ack clears", {31'b0, irq}, 32'h0);
        stop_and_ack();
    endtask

    task automatic t_free_r6();
        wr(5'h00, 32'h3);
        wr(5'h08, 32'h1);
        repeat (4) @(negedge clk);
        rd(5'h04, rv);
        check("R6 wrap to all ones", rv, 32'hFFFF_FFFF);
        check("R6 event at wrap", {31'b0, irq}, 32'h1);
        rd(5'h04, rv);
        rd(5'h04, rv2);
        check("R6 inverse increases", ((~rv2) > (~rv)) ? 32'h1 : 32'h0, 32'h1);
        stop_and_ack();
    endtask

    task automatic t_stop_r7();
        wr(5'h00, 32'h8);
        wr(5'h08, 32'h3);
        wr(5'h08, 32'h6);
        rd(5'h04, rv);
        repeat (20) @(negedge clk);
        rd(5'h04, rv2);
        check("R7 value holds when stopped", rv2, rv);
        wr(5'h08, 32'h2);                    // stay off, unmask
        check("R7 no event while stopped", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_mask_r8();
        wr(5'h00, 32'hF);
        wr(5'h08, 32'h7);
        repeat (20) @(negedge clk);
        check("R8 masked irq low", {31'b0, irq}, 32'h0);
        rd(5'h10, rv);
        check("R8 masked status", rv, 32'h0);
        wr(5'h08, 32'h3);
        check("R8 latched event shows on unmask", {31'b0, irq}, 32'h1);
        rd(5'h10, rv);
        check("R8 status bit", rv, 32'h1);
    endtask

    task automatic t_ignored_r10();
        wr(5'h08, 32'h2);                    // stop, unmasked, event pending
        rd(5'h04, rv);
        wr(5'h04, 32'h1234_5678);
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'h0);
        rd(5'h04, rv2);
        check("R10 value write ignored", rv2, rv);
        check("R10 ack/status writes ignored", {31'b0, irq}, 32'h1);
        rd(5'h0C, rv);
    endtask

    task automatic t_midrun_r11();
        int n;
        wr(5'h00, 32'h40);
        wr(5'h08, 32'h3);
        wr(5'h00, 32'h5);
        rd(5'h04, rv);
        check("R11 reload write keeps count", rv, 32'h3F);
        wr(5'h08, 32'h3);
        rd(5'h04, rv);
        check("R11 enable rewrite no reload", rv, 32'h3D);
        n = 0;
        while (!irq && n < 200) begin @(negedge clk); n++; end
        rd(5'h04, rv);
        check("R11 new reload used", rv, 32'h5);
        stop_and_ack();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_regs_r2_r3();
        t_count_r4();
        t_period_r5_r9();
        t_free_r6();
        t_stop_r7();
        t_mask_r8();
        t_ignored_r10();
        t_midrun_r11();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule